// File: doc/BRIEF.md
# Programmable sample-interval timer

This block sets the pace of an acquisition system by issuing a conversion trigger at a programmed interval. A 12-bit reload value is shifted in one bit at a time. A preset pulse then copies that value into a 12-bit down-counter. The counter decrements on a count enable. That enable is either an internal rate tick or the rising edge of an external clock, which is synchronized first. Each time the counter passes through zero, it reloads itself and raises an interrupt flag.

A single hardware wrap is too short for long intervals. An extension counter therefore counts wraps, and a trigger is only allowed on every (E+1)th wrap, where E is the extension count. The trigger reaches the output only while both the run/stop input and the trigger-enable input are high. The interrupt flag stays set until it is acknowledged.

Top module: `sample_interval_timer`

## Requirements
- R1: During and after an active-low reset, trig_o and irq_o are 0. The reload latch, the down-counter and the extension counter are all 0.
- R2: In every cycle with ser_shift_i high, the reload latch shifts one place toward its MSB and takes ser_data_i into bit 0. After 12 or more shifts, the latch holds the last 12 bits in order, with the earliest of them in bit 11. Shifting does not change the counter until the next preset.
- R3: A cycle with preset_i high loads the counter from the reload latch and loads the extension counter from ext_count_i. In that cycle the counter neither counts nor wraps.
- R4: When src_sel_i is 0 (internal), the counter counts on each cycle with tick_i high. A count at a nonzero value decrements the counter. A count at zero reloads the counter from the latch and is a wrap, so a reload value L gives one wrap per L+1 counts.
- R5: When src_sel_i is 1 (external), tick_i is ignored. The count enable is a rising edge of ext_clk_i, seen through a two-flop synchronizer and an edge detector, and acts three clock edges after the input rises.
- R6: A wrap sets irq_o in the next cycle. irq_o then stays high until a cycle with irq_ack_i high and no wrap clears it. A wrap wins over an acknowledge in the same cycle.
- R7: On a wrap with the extension counter at 0, the extension condition is satisfied and the extension counter reloads from ext_count_i. On any other wrap, the extension counter decrements. With E applied, a satisfied wrap therefore occurs once per E+1 wraps.
- R8: trig_o is high for the one cycle after a wrap that satisfies the extension condition, and only if run_i and trig_en_i were both high at that wrap. An ungated satisfied wrap still reloads the extension counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Internal rate count enable |
| ser_data_i | input | 1 | Serial reload data bit |
| ser_shift_i | input | 1 | Shift strobe for the reload latch |
| preset_i | input | 1 | Load counter and extension from latch and ext_count_i |
| src_sel_i | input | 1 | Count source: 0 internal tick, 1 external clock |
| ext_clk_i | input | 1 | Asynchronous external count clock |
| ext_count_i | input | 12 | Extension count E (wraps per trigger minus one) |
| run_i | input | 1 | Run/stop gate |
| trig_en_i | input | 1 | Trigger enable gate |
| irq_ack_i | input | 1 | Clears the pending interrupt |
| trig_o | output | 1 | Conversion trigger pulse |
| irq_o | output | 1 | Pending wrap interrupt |

## Verification
The bench checks the wrap spacing for more than one reload value and for a tick that arrives only every other cycle. An off-by-one in the zero reload would give L or L+2 counts per period and shift every later trigger. It runs an extension count of two, so a decrementer that reloads at the wrong point shows up as 32 or 34 triggers instead of 33. It shifts 13 bits so that the first one must fall off the top, and it drives tick_i high while the external source is selected, so a leak from the wrong source shows up as extra wraps. It closes the run gate while wraps continue, and holds the interrupt without acknowledge and then clears it, so that a dropped flag or a gated interrupt is caught.

// File: rtl/sit_pkg.sv
package sit_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } clk_src_e;
endpackage

// File: rtl/sit_shift_latch.sv
module sit_shift_latch #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (shift_i) q_q <= {q_q[W-2:0], data_i};
  end

  assign q_o = q_q;
endmodule

// File: rtl/sit_edge_sync.sv
module sit_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  localparam int N = STAGES + 1;

  logic [N-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[N-2:0], async_i};
  end

  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/sit_down_counter.sv
module sit_down_counter #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         preset_i,
  input  logic         en_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);
  assign wrap_o  = en_i & at_zero & ~preset_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (preset_i) cnt_q <= reload_i;
    else if (en_i)     cnt_q <= at_zero ? reload_i : cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sit_extension.sv
module sit_extension #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         preset_i,
  input  logic         wrap_i,
  input  logic [W-1:0] ext_count_i,
  input  logic         run_i,
  input  logic         trig_en_i,
  output logic [W-1:0] rem_o,
  output logic         trig_o
);
  logic [W-1:0] rem_q;
  logic         trig_q;
  logic         done;

  assign done = wrap_i & (rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rem_q <= '0;
    else if (preset_i) rem_q <= ext_count_i;
    else if (wrap_i)   rem_q <= done ? ext_count_i : rem_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= done & run_i & trig_en_i;
  end

  assign rem_o  = rem_q;
  assign trig_o = trig_q;
endmodule

// File: rtl/sample_interval_timer.sv
module sample_interval_timer #(
  parameter int CNT_W = 12,
  parameter int EXT_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ser_data_i,
  input  logic             ser_shift_i,
  input  logic             preset_i,
  input  logic             src_sel_i,
  input  logic             ext_clk_i,
  input  logic [EXT_W-1:0] ext_count_i,
  input  logic             run_i,
  input  logic             trig_en_i,
  input  logic             irq_ack_i,
  output logic             trig_o,
  output logic             irq_o
);
  import sit_pkg::*;

  logic [CNT_W-1:0] latch_q;
  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] rem_q;
  logic             ext_rise;
  logic             cnt_en;
  logic             wrap;
  logic             irq_q;
  clk_src_e         src;

  assign src = clk_src_e'(src_sel_i);

  sit_shift_latch #(.W(CNT_W)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (ser_shift_i),
    .data_i  (ser_data_i),
    .q_o     (latch_q)
  );

  sit_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ext_clk_i),
    .rise_o  (ext_rise)
  );

  always_comb begin
    unique case (src)
      SRC_EXT: cnt_en = ext_rise;
      default: cnt_en = tick_i;
    endcase
  end

  sit_down_counter #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .preset_i (preset_i),
    .en_i     (cnt_en),
    .reload_i (latch_q),
    .cnt_o    (cnt_q),
    .wrap_o   (wrap)
  );

  sit_extension #(.W(EXT_W)) u_ext (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .preset_i    (preset_i),
    .wrap_i      (wrap),
    .ext_count_i (ext_count_i),
    .run_i       (run_i),
    .trig_en_i   (trig_en_i),
    .rem_o       (rem_q),
    .trig_o      (trig_o)
  );

  // set wins over acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (wrap)      irq_q <= 1'b1;
    else if (irq_ack_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/sit_checker.sv
module sit_checker #(
  parameter int CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ser_shift_i,
  input logic             ser_data_i,
  input logic             preset_i,
  input logic             run_i,
  input logic             trig_en_i,
  input logic             irq_ack_i,
  input logic             wrap,
  input logic [CNT_W-1:0] latch_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             trig_o,
  input logic             irq_o
);
  a_r2_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_shift_i |=> latch_q[0] == $past(ser_data_i));

  a_r3_preset_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_i |=> cnt_q == $past(latch_q));

  a_r6_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o);

  a_r6_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> irq_o);

  a_r6_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !wrap) |=> !irq_o);

  a_r8_trig_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_i && trig_en_i) |=> !trig_o);

  a_r8_trig_needs_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> !trig_o);
endmodule

bind sample_interval_timer sit_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ser_shift_i (ser_shift_i),
  .ser_data_i  (ser_data_i),
  .preset_i    (preset_i),
  .run_i       (run_i),
  .trig_en_i   (trig_en_i),
  .irq_ack_i   (irq_ack_i),
  .wrap        (wrap),
  .latch_q     (latch_q),
  .cnt_q       (cnt_q),
  .trig_o      (trig_o),
  .irq_o       (irq_o)
);

// File: tb/sample_interval_timer_test.sv
`timescale 1ns/1ps
module sample_interval_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, sdata = 1'b0, sshift = 1'b0, preset = 1'b0;
  logic src = 1'b0, eclk = 1'b0, run = 1'b0, ten = 1'b0, ack = 1'b0;
  logic [11:0] ecnt = '0;
  logic trig, irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  sample_interval_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ser_data_i(sdata),
    .ser_shift_i(sshift), .preset_i(preset), .src_sel_i(src),
    .ext_clk_i(eclk), .ext_count_i(ecnt), .run_i(run), .trig_en_i(ten),
    .irq_ack_i(ack), .trig_o(trig), .irq_o(irq)
  );

  // behavioural reference
  int m_latch, m_cnt, m_ext;
  bit m_trig, m_irq, m_s1, m_s2, m_s3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_latch = 0; m_cnt = 0; m_ext = 0;
      m_trig = 0; m_irq = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      bit en, wr;
      en = src ? (m_s2 && !m_s3) : tick;
      wr = !preset && en && (m_cnt == 0);
      m_trig = wr && (m_ext == 0) && run && ten;
      if (wr) m_irq = 1;
      else if (ack) m_irq = 0;
      if (preset) m_ext = ecnt;
      else if (wr) m_ext = (m_ext == 0) ? ecnt : m_ext - 1;
      if (preset) m_cnt = m_latch;
      else if (en) m_cnt = (m_cnt == 0) ? m_latch : m_cnt - 1;
      if (sshift) m_latch = ((m_latch << 1) | sdata) & 12'hfff;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = eclk;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (trig !== m_trig) begin
        errors++;
        $display("FAIL %s trig_o actual %0b expected %0b", tag, trig, m_trig);
      end
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL %s irq_o actual %0b expected %0b", tag, irq, m_irq);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic shift_bits(input int v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      sshift = 1'b1; sdata = v[i];
    end
    @(negedge clk);
    sshift = 1'b0; sdata = 1'b0;
  endtask

  task automatic do_preset();
    @(negedge clk); preset = 1'b1;
    @(negedge clk); preset = 1'b0;
  endtask

  // tick_mode: 0 hold, 1 alternate; ext_half > 0 toggles ext clock
  task automatic run_for(input int n, input bit auto_ack, input int ext_half,
                         input int tick_mode, output int ntrig);
    ntrig = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (trig) ntrig++;
      ack = auto_ack & irq;
      if (ext_half > 0 && (i % ext_half) == 0) eclk = ~eclk;
      if (tick_mode == 1) tick = ~tick;
    end
    ack = 1'b0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 trig_o in reset", trig, 0);
    check("R1 irq_o in reset", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 trig_o after reset", trig, 0);
    check("R1 irq_o after reset", irq, 0);

    tag = "R3/R4";
    shift_bits(3, 12);
    tick = 1'b1; run = 1'b1; ten = 1'b1; ecnt = 12'd0;
    do_preset();
    run_for(402, 1'b1, 0, 0, n);
    check("R3/R4 triggers for reload 3", n, 100);

    tag = "R7";
    ecnt = 12'd2;
    do_preset();
    run_for(402, 1'b1, 0, 0, n);
    check("R7 triggers with extension 2", n, 33);

    tag = "R8";
    ecnt = 12'd0; run = 1'b0;
    do_preset();
    run_for(200, 1'b1, 0, 0, n);
    check("R8 no trigger with run low", n, 0);
    run = 1'b1; ten = 1'b0;
    run_for(200, 1'b1, 0, 0, n);
    check("R8 no trigger with enable low", n, 0);
    ten = 1'b1;

    tag = "R6";
    run_for(50, 1'b0, 0, 0, n);
    check("R6 irq_o held without ack", irq, 1);
    tick = 1'b0;
    run_for(3, 1'b0, 0, 0, n);
    check("R6 irq_o still held", irq, 1);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check("R6 irq_o cleared by ack", irq, 0);

    tag = "R2";
    shift_bits(13'h1005, 13);
    tick = 1'b1;
    run_for(30, 1'b1, 0, 0, n);
    do_preset();
    run_for(602, 1'b1, 0, 0, n);
    check("R2 triggers for shifted reload 5", n, 100);

    tag = "R4";
    shift_bits(3, 12);
    do_preset();
    run_for(400, 1'b1, 0, 1, n);
    check("R4 triggers with half-rate tick", n, 50);
    tick = 1'b1;

    tag = "R5";
    shift_bits(1, 12);
    src = 1'b1;
    do_preset();
    run_for(400, 1'b1, 5, 0, n);
    check("R5 external triggers in range", (n >= 19 && n <= 21) ? 1 : 0, 1);
    run_for(20, 1'b1, 0, 0, n);
    check("R5 tick ignored while external selected", n, 0);

    tag = "R3";
    src = 1'b0;
    shift_bits(9, 12);
    do_preset();
    run_for(7, 1'b1, 0, 0, n);
    do_preset();
    run_for(100, 1'b1, 0, 0, n);
    check("R3 represet restarts period", n, 10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule